// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges every reset request of a small microcontroller into one synchronous system reset for the CPU and its peripherals. The requests are: power-on, an active-low external reset pin, a software request bit, a watchdog overflow pulse, a low-voltage flag, a CPU-activity monitor overflow pulse and a clock-failure flag. The analog detectors and the oscillator are not part of the block. Each one reaches it only as a digital input.

Power-on is the asynchronous reset of the block. Once it goes away, the controller counts a fixed oscillator-settle interval of `2**STAB_LOG2` clocks. After that it counts a short release delay of `REL_DLY` clocks and then lets the CPU go. The other sources skip the settle interval. They hold the reset while their request is present and release it `REL_DLY` clocks after the request goes away. At release, a one-cycle pulse tells the CPU to fetch from its reset vector. The watchdog is held stopped for as long as the reset lasts. While a reset caused by a clock failure is in progress, an output selects the internal RC clock. A sticky cause register records which sources have fired.

All pins are plain control and status levels. The block has no data stream, so it has no valid/ready handshake.

Top module: `rstc_top`

## Requirements
- R1: While `por_i` is high, `sys_rst_n_o` is 0, `wdt_stop_o` is 1 and `cause_o` equals 7'b0000001. The cause bits are: bit0 power-on, bit1 external pin, bit2 software, bit3 watchdog, bit4 low voltage, bit5 CPU monitor, bit6 clock failure.
- R2: After `por_i` falls, with no other request, `sys_rst_n_o` rises exactly `2**STAB_LOG2 + REL_DLY` clock edges later.
- R3: For the non-power-on sources there is no settle interval. A watchdog pulse of one cycle drives `sys_rst_n_o` low on the next edge, and the reset is released `REL_DLY + 1` edges after the pulse ends.
- R4: The external pin passes through two synchronizer flops and must be seen low on two consecutive synchronized samples. A low lasting one clock is ignored. A longer low asserts the reset, and the release comes `REL_DLY + 4` edges after the pin returns high.
- R5: Writing 0 to the software bit (`sw_we_i` with `sw_wdata_i`=0) requests a reset. The bit reads 1 again on the edge at which the reset begins. Writing 1 has no effect.
- R6: Each cause flag is set when its source requests a reset and stays set until software writes 1 to it through `cause_clr_i`. Bits written 0 are unchanged, and a set in the same cycle wins over a clear. Power-on clears every flag except bit0.
- R7: `wdt_stop_o` is 1 whenever `sys_rst_n_o` is 0.
- R8: `vec_fetch_o` is a one-cycle pulse in the first cycle in which `sys_rst_n_o` is 1.
- R9: `rc_clk_sel_o` is 1 from the edge after a clock-failure request is seen until the reset is released, and it is never 1 outside reset.
- R10: A request during the release delay restarts the sequence, and release then follows `REL_DLY + 1` edges after that request ends. A request during the settle count restarts the full settle count, so power-on timing takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Machine clock |
| por_i | input | 1 | Power-on indication, active high, asynchronous |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| wdt_ovf_i | input | 1 | Watchdog overflow pulse |
| lvd_i | input | 1 | Low-voltage detect flag |
| cpu_ovf_i | input | 1 | CPU-activity monitor overflow pulse |
| clk_fail_i | input | 1 | Clock-failure flag |
| sw_we_i | input | 1 | Write strobe for the software reset bit |
| sw_wdata_i | input | 1 | Value written to the software reset bit (0 requests a reset) |
| cause_clr_we_i | input | 1 | Write strobe for the cause register |
| cause_clr_i | input | 7 | Write-one-to-clear mask for the cause flags |
| sys_rst_n_o | output | 1 | System reset to the CPU and peripherals, active low |
| wdt_stop_o | output | 1 | Holds the watchdog stopped |
| vec_fetch_o | output | 1 | One-cycle pulse at release: fetch the reset vector |
| rc_clk_sel_o | output | 1 | Selects the internal RC clock during a clock-failure reset |
| sw_bit_o | output | 1 | Read value of the software reset bit |
| cause_o | output | 7 | Sticky reset-cause flags |

## Verification
The hardest cases to reach are the two restarts. In one, a request lands inside the release delay; in the other, it lands inside the power-on settle count. Either restart is visible only as a release that comes later than it otherwise would. The stimulus counts edges from a known point, either the fall of power-on or the end of a low-voltage request, and injects a one-cycle watchdog or CPU-monitor pulse at a chosen count. It then measures the exact number of edges to release. The settle count is shortened by parameter so the stabilization window can be reached directly.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int NSRC    = 7;
  localparam int SRC_POR = 0;
  localparam int SRC_EXT = 1;
  localparam int SRC_SW  = 2;
  localparam int SRC_WDT = 3;
  localparam int SRC_LVD = 4;
  localparam int SRC_CPU = 5;
  localparam int SRC_CLK = 6;

  typedef enum logic [1:0] {
    ST_STAB = 2'd0,
    ST_HOLD = 2'd1,
    ST_DLY  = 2'd2,
    ST_RUN  = 2'd3
  } seq_st_e;
endpackage

// File: rtl/rstc_pin_filt.sv
// Synchronizes the external pin and accepts a low only after it has been
// seen on FILT_LEN consecutive synchronized samples.
module rstc_pin_filt #(
  parameter int SYNC_W   = 2,
  parameter int FILT_LEN = 2
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic pin_n_i,
  output logic req_o
);
  logic [SYNC_W-1:0]   sync_q;
  logic [FILT_LEN-1:0] hist_q;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      sync_q <= '1;
      hist_q <= '1;
    end else begin
      sync_q <= {sync_q[SYNC_W-2:0], pin_n_i};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_W-1]};
    end
  end

  assign req_o = ~|hist_q;
endmodule

// File: rtl/rstc_seq.sv
// Reset sequencer: settle count after power-on, hold while requests are
// present, release delay, run.
module rstc_seq
  import rstc_pkg::*;
#(
  parameter int STAB_LOG2 = 16,
  parameter int REL_DLY   = 4,
  parameter int NREQ      = 6
) (
  input  logic            clk_i,
  input  logic            por_i,
  input  logic [NREQ-1:0] req_i,
  input  logic            clk_req_i,
  output logic            run_o,
  output logic            in_rst_o,
  output logic            fetch_o,
  output logic            rc_sel_o
);
  localparam int DLY_W = $clog2(REL_DLY + 1);
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(REL_DLY - 1);

  seq_st_e              state_q, state_d;
  logic [STAB_LOG2-1:0] stab_q, stab_d;
  logic [DLY_W-1:0]     dly_q, dly_d;
  logic                 run_q, fetch_q, rc_q;
  logic                 any_req;

  assign any_req = |req_i;

  always_comb begin
    state_d = state_q;
    stab_d  = stab_q;
    dly_d   = dly_q;
    unique case (state_q)
      ST_STAB: begin
        if (any_req) begin
          stab_d = '0;
        end else if (&stab_q) begin
          state_d = ST_DLY;
          dly_d   = '0;
        end else begin
          stab_d = stab_q + 1'b1;
        end
      end
      ST_HOLD: begin
        if (!any_req) begin
          state_d = ST_DLY;
          dly_d   = '0;
        end
      end
      ST_DLY: begin
        if (any_req) begin
          state_d = ST_HOLD;
        end else if (dly_q == DLY_LAST) begin
          state_d = ST_RUN;
        end else begin
          dly_d = dly_q + 1'b1;
        end
      end
      ST_RUN: begin
        if (any_req) state_d = ST_HOLD;
      end
      default: state_d = ST_STAB;
    endcase
  end

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      state_q <= ST_STAB;
      stab_q  <= '0;
      dly_q   <= '0;
      run_q   <= 1'b0;
      fetch_q <= 1'b0;
      rc_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      stab_q  <= stab_d;
      dly_q   <= dly_d;
      run_q   <= (state_d == ST_RUN);
      fetch_q <= (state_d == ST_RUN) && (state_q != ST_RUN);
      if (clk_req_i)              rc_q <= 1'b1;
      else if (state_d == ST_RUN) rc_q <= 1'b0;
    end
  end

  assign run_o    = run_q;
  assign in_rst_o = (state_q != ST_RUN);
  assign fetch_o  = fetch_q;
  assign rc_sel_o = rc_q;
endmodule

// File: rtl/rstc_regs.sv
// Software reset bit (self-restoring to 1) and sticky write-1-to-clear causes.
module rstc_regs
  import rstc_pkg::*;
(
  input  logic            clk_i,
  input  logic            por_i,
  input  logic [NSRC-1:1] set_i,
  input  logic            clr_we_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic            sw_we_i,
  input  logic            sw_wdata_i,
  output logic            sw_bit_o,
  output logic [NSRC-1:0] cause_o
);
  localparam logic [NSRC-1:0] POR_CAUSE = NSRC'(1) << SRC_POR;

  logic            sw_q;
  logic [NSRC-1:0] cause_q;
  logic [NSRC-1:0] clr_mask;

  assign clr_mask = clr_we_i ? clr_i : '0;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      sw_q    <= 1'b1;
      cause_q <= POR_CAUSE;
    end else begin
      if (!sw_q)                      sw_q <= 1'b1;
      else if (sw_we_i && !sw_wdata_i) sw_q <= 1'b0;
      cause_q <= (cause_q & ~clr_mask) | {set_i, 1'b0};
    end
  end

  assign sw_bit_o = sw_q;
  assign cause_o  = cause_q;
endmodule

// File: rtl/rstc_top.sv
module rstc_top
  import rstc_pkg::*;
#(
  parameter int STAB_LOG2 = 16,
  parameter int REL_DLY   = 4,
  parameter int SYNC_W    = 2,
  parameter int FILT_LEN  = 2
) (
  input  logic            clk_i,
  input  logic            por_i,
  input  logic            ext_rst_n_i,
  input  logic            wdt_ovf_i,
  input  logic            lvd_i,
  input  logic            cpu_ovf_i,
  input  logic            clk_fail_i,
  input  logic            sw_we_i,
  input  logic            sw_wdata_i,
  input  logic            cause_clr_we_i,
  input  logic [NSRC-1:0] cause_clr_i,
  output logic            sys_rst_n_o,
  output logic            wdt_stop_o,
  output logic            vec_fetch_o,
  output logic            rc_clk_sel_o,
  output logic            sw_bit_o,
  output logic [NSRC-1:0] cause_o
);
  logic            ext_req;
  logic            sw_bit;
  logic [NSRC-1:1] req_vec;

  rstc_pin_filt #(.SYNC_W(SYNC_W), .FILT_LEN(FILT_LEN)) u_pin (
    .clk_i   (clk_i),
    .por_i   (por_i),
    .pin_n_i (ext_rst_n_i),
    .req_o   (ext_req)
  );

  assign req_vec[SRC_EXT] = ext_req;
  assign req_vec[SRC_SW]  = !sw_bit;
  assign req_vec[SRC_WDT] = wdt_ovf_i;
  assign req_vec[SRC_LVD] = lvd_i;
  assign req_vec[SRC_CPU] = cpu_ovf_i;
  assign req_vec[SRC_CLK] = clk_fail_i;

  rstc_seq #(.STAB_LOG2(STAB_LOG2), .REL_DLY(REL_DLY), .NREQ(NSRC-1)) u_seq (
    .clk_i     (clk_i),
    .por_i     (por_i),
    .req_i     (req_vec),
    .clk_req_i (clk_fail_i),
    .run_o     (sys_rst_n_o),
    .in_rst_o  (wdt_stop_o),
    .fetch_o   (vec_fetch_o),
    .rc_sel_o  (rc_clk_sel_o)
  );

  rstc_regs u_regs (
    .clk_i      (clk_i),
    .por_i      (por_i),
    .set_i      (req_vec),
    .clr_we_i   (cause_clr_we_i),
    .clr_i      (cause_clr_i),
    .sw_we_i    (sw_we_i),
    .sw_wdata_i (sw_wdata_i),
    .sw_bit_o   (sw_bit),
    .cause_o    (cause_o)
  );

  assign sw_bit_o = sw_bit;
endmodule

// File: rtl/rstc_chk.sv
module rstc_chk (
  input logic       clk_i,
  input logic       por_i,
  input logic       wdt_ovf_i,
  input logic       lvd_i,
  input logic       cpu_ovf_i,
  input logic       clk_fail_i,
  input logic       cause_clr_we_i,
  input logic       sys_rst_n_o,
  input logic       wdt_stop_o,
  input logic       vec_fetch_o,
  input logic       rc_clk_sel_o,
  input logic       sw_bit_o,
  input logic [6:0] cause_o
);
  AST_REQ_ASSERTS_RST: assert property (@(posedge clk_i) disable iff (por_i)
    (wdt_ovf_i || lvd_i || cpu_ovf_i || clk_fail_i || !sw_bit_o) |=> !sys_rst_n_o); // R3

  AST_WDT_HELD: assert property (@(posedge clk_i) disable iff (por_i)
    !sys_rst_n_o |-> wdt_stop_o); // R7

  AST_FETCH_ON_RELEASE: assert property (@(posedge clk_i) disable iff (por_i)
    vec_fetch_o |-> (sys_rst_n_o && !$past(sys_rst_n_o))); // R8

  AST_SW_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (por_i)
    !sw_bit_o |=> sw_bit_o); // R5

  AST_CAUSE_STICKY: assert property (@(posedge clk_i) disable iff (por_i)
    !cause_clr_we_i |=> ((cause_o & $past(cause_o)) == $past(cause_o))); // R6

  AST_RC_IN_RESET: assert property (@(posedge clk_i) disable iff (por_i)
    rc_clk_sel_o |-> !sys_rst_n_o); // R9
endmodule

bind rstc_top rstc_chk i_chk (
  .clk_i          (clk_i),
  .por_i          (por_i),
  .wdt_ovf_i      (wdt_ovf_i),
  .lvd_i          (lvd_i),
  .cpu_ovf_i      (cpu_ovf_i),
  .clk_fail_i     (clk_fail_i),
  .cause_clr_we_i (cause_clr_we_i),
  .sys_rst_n_o    (sys_rst_n_o),
  .wdt_stop_o     (wdt_stop_o),
  .vec_fetch_o    (vec_fetch_o),
  .rc_clk_sel_o   (rc_clk_sel_o),
  .sw_bit_o       (sw_bit_o),
  .cause_o        (cause_o)
);

// File: tb/test_rstc_top.sv
`timescale 1ns/1ps
module test_rstc_top;
  localparam int STAB_LOG2 = 5;
  localparam int STAB      = 1 << STAB_LOG2;
  localparam int DLY       = 4;
  localparam int S_RST = 0, S_CAUSE = 1, S_WDT = 2, S_FETCH = 3, S_SW = 4, S_RC = 5;

  logic clk = 1'b0;
  logic por = 1'b1, ext_n = 1'b1, wdt = 1'b0, lvd = 1'b0, cpu = 1'b0, cfail = 1'b0;
  logic sw_we = 1'b0, sw_wd = 1'b1, clr_we = 1'b0;
  logic [6:0] clr = '0;
  logic sys_rst_n, wdt_stop, vec_fetch, rc_sel, sw_bit;
  logic [6:0] cause;

  always #4 clk = ~clk;

  rstc_top #(.STAB_LOG2(STAB_LOG2), .REL_DLY(DLY)) i_rstc_top (
    .clk_i(clk), .por_i(por), .ext_rst_n_i(ext_n), .wdt_ovf_i(wdt), .lvd_i(lvd),
    .cpu_ovf_i(cpu), .clk_fail_i(cfail), .sw_we_i(sw_we), .sw_wdata_i(sw_wd),
    .cause_clr_we_i(clr_we), .cause_clr_i(clr), .sys_rst_n_o(sys_rst_n),
    .wdt_stop_o(wdt_stop), .vec_fetch_o(vec_fetch), .rc_clk_sel_o(rc_sel),
    .sw_bit_o(sw_bit), .cause_o(cause)
  );

  typedef struct {
    string       tag;
    int          sel;
    logic [31:0] exp;
    logic [31:0] act;
  } item_t;

  item_t sb_q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  function automatic logic [31:0] obs(int sel);
    case (sel)
      S_RST:   return {31'd0, sys_rst_n};
      S_CAUSE: return {25'd0, cause};
      S_WDT:   return {31'd0, wdt_stop};
      S_FETCH: return {31'd0, vec_fetch};
      S_SW:    return {31'd0, sw_bit};
      S_RC:    return {31'd0, rc_sel};
      default: return 32'hdead;
    endcase
  endfunction

  task automatic expect_out(string tag, int sel, logic [31:0] exp);
    sb_q.push_back('{tag, sel, exp, 32'd0});
  endtask

  task automatic expect_val(string tag, logic [31:0] exp, logic [31:0] act);
    sb_q.push_back('{tag, -1, exp, act});
  endtask

  // monitor: pops expected items and compares them with the outputs
  always @(negedge clk) begin
    #1;
    while (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] a;
      it = sb_q.pop_front();
      a = (it.sel < 0) ? it.act : obs(it.sel);
      n_chk++;
      if (a !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %0h expected %0h", it.tag, a, it.exp);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sys_rst_n && n < 300);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    // R1 reset state
    cyc(2);
    expect_out("R1 rst low in por", S_RST, 0);
    expect_out("R1 cause por only", S_CAUSE, 7'b0000001);
    expect_out("R7 wdt stopped in por", S_WDT, 1);
    por = 1'b0;
    // R2 settle plus release delay
    cyc(STAB + DLY - 1);
    expect_out("R2 still low before settle end", S_RST, 0);
    cyc(1);
    expect_out("R2 released after settle", S_RST, 1);
    expect_out("R8 fetch pulse at release", S_FETCH, 1);
    expect_out("R7 wdt runs after release", S_WDT, 0);
    cyc(1);
    expect_out("R8 fetch pulse one cycle", S_FETCH, 0);

    // R4 one-cycle glitch ignored
    ext_n = 1'b0;
    cyc(1);
    ext_n = 1'b1;
    cyc(8);
    expect_out("R4 glitch ignored", S_RST, 1);
    expect_out("R4 glitch not recorded", S_CAUSE, 7'b0000001);

    // R4 long low accepted
    ext_n = 1'b0;
    cyc(6);
    expect_out("R4 ext low accepted", S_RST, 0);
    expect_out("R6 ext cause set", S_CAUSE, 7'b0000011);
    ext_n = 1'b1;
    measure(n);
    expect_val("R4 ext release timing", DLY + 4, n);

    // R6 write-one-to-clear
    clr_we = 1'b1; clr = 7'b0000001;
    cyc(1);
    clr_we = 1'b0;
    expect_out("R6 clear por flag", S_CAUSE, 7'b0000010);
    clr_we = 1'b1; clr = 7'b0000000;
    cyc(1);
    expect_out("R6 zero write no effect", S_CAUSE, 7'b0000010);
    clr = 7'b0000010;
    cyc(1);
    clr_we = 1'b0; clr = '0;
    expect_out("R6 clear ext flag", S_CAUSE, 7'b0000000);

    // R5 software bit
    sw_we = 1'b1; sw_wd = 1'b1;
    cyc(1);
    sw_we = 1'b0;
    cyc(4);
    expect_out("R5 write 1 no reset", S_RST, 1);
    expect_out("R5 write 1 bit reads 1", S_SW, 1);
    expect_out("R5 write 1 no cause", S_CAUSE, 7'b0000000);
    sw_we = 1'b1; sw_wd = 1'b0;
    cyc(1);
    sw_we = 1'b0; sw_wd = 1'b1;
    expect_out("R5 bit reads 0 after write", S_SW, 0);
    cyc(1);
    expect_out("R5 sw reset asserted", S_RST, 0);
    expect_out("R5 bit restored to 1", S_SW, 1);
    expect_out("R6 sw cause set", S_CAUSE, 7'b0000100);
    measure(n);
    expect_val("R5 sw release timing", DLY + 1, n);

    // R3 watchdog, no settle count
    cyc(2);
    wdt = 1'b1;
    cyc(1);
    wdt = 1'b0;
    expect_out("R3 wdt reset next edge", S_RST, 0);
    expect_out("R7 wdt stop during reset", S_WDT, 1);
    expect_out("R6 wdt cause set", S_CAUSE, 7'b0001100);
    measure(n);
    expect_val("R3 wdt release timing", DLY + 1, n);

    // R9 clock failure
    cyc(2);
    expect_out("R9 rc off in run", S_RC, 0);
    cfail = 1'b1;
    cyc(2);
    expect_out("R9 rc selected", S_RC, 1);
    expect_out("R9 rst low on clock fail", S_RST, 0);
    cfail = 1'b0;
    measure(n);
    expect_val("R9 clkfail release timing", DLY + 1, n);
    expect_out("R9 rc off after release", S_RC, 0);
    expect_out("R6 clk cause set", S_CAUSE, 7'b1001100);

    // R10 request inside release delay
    cyc(2);
    lvd = 1'b1;
    cyc(2);
    lvd = 1'b0;
    cyc(2);
    cpu = 1'b1;
    cyc(1);
    cpu = 1'b0;
    expect_out("R10 rst low after restart", S_RST, 0);
    measure(n);
    expect_val("R10 delay restart timing", DLY + 1, n);
    expect_out("R6 lvd and cpu causes", S_CAUSE, 7'b1111100);

    // R10 request inside settle count, R1 por clears other flags
    cyc(2);
    por = 1'b1;
    cyc(1);
    expect_out("R1 rst low on por", S_RST, 0);
    expect_out("R1 por clears others", S_CAUSE, 7'b0000001);
    por = 1'b0;
    cyc(10);
    wdt = 1'b1;
    cyc(1);
    wdt = 1'b0;
    measure(n);
    expect_val("R10 settle restart timing", STAB + DLY, n);
    expect_out("R6 wdt during settle", S_CAUSE, 7'b0001001);

    cyc(3);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule